// File: doc/BRIEF.md
# Ethernet Frame Generator

This block is a software-driven traffic source. It assembles Ethernet frames and sends them out as beats on a 32-bit packet stream with a valid/ready handshake, start and end markers and a count of empty bytes. Each frame carries a destination address, a source address, a two-byte length field holding the payload length, and then the payload. The frame check sequence, preamble and gap timing are added further down the path.

Software sets the block up through a word-wide register port. It programs the number of frames, both MAC addresses, the payload length, whether that length is fixed or a bounded random draw, and whether payload bytes count upward or come from a pseudo-random source. It then writes the start register. The block sends the programmed number of frames and goes idle. A stop request ends the run early, but only at a frame boundary. A read-only counter reports how many frames went out.

Top module: `eth_frame_gen`

## Requirements
- R1: The registers sit at these byte offsets: 0x00 frame count (32 bits), 0x04 length mode (bit 0), 0x08 payload mode (bit 0), 0x0C start (bit 0), 0x10 stop (bit 0), 0x14 and 0x18 source address bits 31:0 and 47:32, 0x1C and 0x20 destination address bits 31:0 and 47:32, 0x24 transmitted count, 0x34 payload length (16 bits). Reads return the stored value zero-extended. Every register reads zero after reset, and an unmapped offset reads zero.
- R2: In the two address-high registers, bits 31:16 of a write are dropped and always read as zero.
- R3: The transmitted count is read-only, and writes to it have no effect. It clears to zero on every start accepted while the block is idle, and it rises by one as each frame's last beat is accepted.
- R4: Writing 1 in bit 0 of the start register while idle sends exactly the programmed number of frames and then leaves valid low. A count of zero sends nothing. A start written during a run is ignored.
- R5: Writing 1 in bit 0 of the stop register during a run ends the run after the frame in flight, which always completes. If the stop arrives in the same cycle as that frame's last-beat handshake, no further frame starts. A stop written while idle has no effect.
- R6: A frame is sent as 6 destination address bytes (bit 47 first), then 6 source address bytes (bit 47 first), then the payload length (high byte first), then the payload bytes.
- R7: In fixed length mode (bit 0 = 0), every payload is the programmed length. A programmed length of 0 is sent as 1.
- R8: In random length mode (bit 0 = 1), a frame's payload length is (r[15:0] × (L+1)) >> 16, where r is the generator state when the frame is launched and L is the programmed length. A result of 0 becomes 1, so the length never exceeds max(L,1).
- R9: The generator is a 32-bit shift register seeded with 0xACE12468 at reset. Each step moves it to {s[30:0], s[31]^s[21]^s[1]^s[0]}. It steps once when a run launches from idle and once on every accepted beat. It is never reseeded by a start.
- R10: In incrementing payload mode (bit 0 = 0), payload byte p is p mod 256. In random mode, a payload byte on lane j (lane 0 = bits 31:24) of a beat is bits 31−8j down to 24−8j of the generator state while that beat is offered.
- R11: Byte 4k+j of a frame travels on lane j of beat k. The start marker is set on beat 0 only and the end marker on the last beat only. On the last beat, empty gives the number of unused trailing bytes, which are zero. Empty is zero on all other beats.
- R12: While valid is high and ready is low, data, markers and empty hold their values, and valid stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | 6 | Register byte offset |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational on reg_addr |
| tx_valid | output | 1 | Stream beat valid |
| tx_ready | input | 1 | Stream sink ready |
| tx_data | output | 32 | Stream data, lane 0 in bits 31:24 |
| tx_sop | output | 1 | First beat of a frame |
| tx_eop | output | 1 | Last beat of a frame |
| tx_empty | output | 2 | Unused trailing bytes on the last beat |

## Verification
Two events can land in the same cycle: the internal stop pulse and the handshake of a frame's last beat. When they coincide, the block must both finish that frame and decline to launch the next one. The bench provokes this by holding ready low on an end-of-packet beat, writing the stop register, and releasing ready on the following cycle, so the stop pulse lines up with the last-beat handshake. The test passes only if exactly one frame appears, the transmitted count reads 1, and valid stays low afterwards. A second run writes a start in the middle of a run. The bench judges it by the final frame total and by the count register, which would have been cleared if the stray start had taken effect.

// File: rtl/efg_pkg.sv
package efg_pkg;
    localparam int unsigned ADDR_W    = 6;
    localparam int unsigned DATA_W    = 32;
    localparam int unsigned LANES     = DATA_W / 8;
    localparam int unsigned LEN_W     = 16;
    localparam int unsigned BEAT_W    = LEN_W;
    localparam int unsigned BYTE_W    = LEN_W + 2;
    localparam int unsigned HDR_BYTES = 14;
    localparam logic [31:0] LFSR_SEED = 32'hACE1_2468;

    localparam logic [ADDR_W-1:0] OFS_COUNT = 6'h00;
    localparam logic [ADDR_W-1:0] OFS_LMODE = 6'h04;
    localparam logic [ADDR_W-1:0] OFS_PMODE = 6'h08;
    localparam logic [ADDR_W-1:0] OFS_START = 6'h0C;
    localparam logic [ADDR_W-1:0] OFS_STOP  = 6'h10;
    localparam logic [ADDR_W-1:0] OFS_SA_LO = 6'h14;
    localparam logic [ADDR_W-1:0] OFS_SA_HI = 6'h18;
    localparam logic [ADDR_W-1:0] OFS_DA_LO = 6'h1C;
    localparam logic [ADDR_W-1:0] OFS_DA_HI = 6'h20;
    localparam logic [ADDR_W-1:0] OFS_TXCNT = 6'h24;
    localparam logic [ADDR_W-1:0] OFS_PLEN  = 6'h34;

    typedef struct packed {
        logic [31:0]      nframes;
        logic             rand_len;
        logic             rand_pay;
        logic [47:0]      sa;
        logic [47:0]      da;
        logic [LEN_W-1:0] plen;
    } cfg_t;

    typedef enum logic {ST_IDLE, ST_SEND} seq_st_e;

    function automatic logic [31:0] lfsr_next(input logic [31:0] s);
        return {s[30:0], s[31] ^ s[21] ^ s[1] ^ s[0]};
    endfunction

    // Payload length for one frame: scaled random draw or the fixed value, never zero.
    function automatic logic [LEN_W-1:0] draw_len(input logic [31:0] r, input logic rnd,
                                                  input logic [LEN_W-1:0] lim);
        logic [32:0] prod;
        logic [LEN_W-1:0] v;
        prod = 33'(r[15:0]) * (33'(lim) + 33'd1);
        v = rnd ? 16'(prod >> 16) : lim;
        if (v == '0) v = 16'd1;
        return v;
    endfunction

    // Header byte at position idx (0..13): destination, source, length field.
    function automatic logic [7:0] hdr_byte(input logic [3:0] idx, input logic [47:0] da,
                                            input logic [47:0] sa, input logic [LEN_W-1:0] len);
        int i;
        i = int'(idx);
        if (i < 6)       return 8'(da >> (8 * (5 - i)));
        else if (i < 12) return 8'(sa >> (8 * (11 - i)));
        else if (i == 12) return len[15:8];
        else             return len[7:0];
    endfunction
endpackage

// File: rtl/efg_regs.sv
module efg_regs
    import efg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr,
    input  logic [31:0]       wdata,
    input  logic [31:0]       txcnt,
    output logic [31:0]       rdata,
    output cfg_t              cfg,
    output logic              start_p,
    output logic              stop_p
);
    always_ff @(posedge clk) begin
        if (rst) begin
            cfg     <= '0;
            start_p <= 1'b0;
            stop_p  <= 1'b0;
        end else begin
            start_p <= wr && (addr == OFS_START) && wdata[0];
            stop_p  <= wr && (addr == OFS_STOP) && wdata[0];
            if (wr) begin
                case (addr)
                    OFS_COUNT: cfg.nframes     <= wdata;
                    OFS_LMODE: cfg.rand_len    <= wdata[0];
                    OFS_PMODE: cfg.rand_pay    <= wdata[0];
                    OFS_SA_LO: cfg.sa[31:0]    <= wdata;
                    OFS_SA_HI: cfg.sa[47:32]   <= wdata[15:0];
                    OFS_DA_LO: cfg.da[31:0]    <= wdata;
                    OFS_DA_HI: cfg.da[47:32]   <= wdata[15:0];
                    OFS_PLEN:  cfg.plen        <= wdata[LEN_W-1:0];
                    default: ;
                endcase
            end
        end
    end

    always_comb begin
        case (addr)
            OFS_COUNT: rdata = cfg.nframes;
            OFS_LMODE: rdata = {31'd0, cfg.rand_len};
            OFS_PMODE: rdata = {31'd0, cfg.rand_pay};
            OFS_START: rdata = {31'd0, start_p};
            OFS_STOP:  rdata = {31'd0, stop_p};
            OFS_SA_LO: rdata = cfg.sa[31:0];
            OFS_SA_HI: rdata = {16'd0, cfg.sa[47:32]};
            OFS_DA_LO: rdata = cfg.da[31:0];
            OFS_DA_HI: rdata = {16'd0, cfg.da[47:32]};
            OFS_TXCNT: rdata = txcnt;
            OFS_PLEN:  rdata = {{(32-LEN_W){1'b0}}, cfg.plen};
            default:   rdata = '0;
        endcase
    end

    assert_mac_hi_R2: assert property (@(posedge clk) disable iff (rst)
        (addr == OFS_SA_HI || addr == OFS_DA_HI) |-> rdata[31:16] == 16'd0);
endmodule

// File: rtl/efg_lfsr.sv
module efg_lfsr
    import efg_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        step,
    output logic [31:0] state
);
    always_ff @(posedge clk) begin
        if (rst)       state <= LFSR_SEED;
        else if (step) state <= lfsr_next(state);
    end

    assert_lfsr_nonzero_R9: assert property (@(posedge clk) disable iff (rst)
        state != 32'd0);
endmodule

// File: rtl/efg_seq.sv
module efg_seq
    import efg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  cfg_t              cfg,
    input  logic              start_p,
    input  logic              stop_p,
    input  logic [31:0]       rnd,
    output logic              lfsr_step,
    output logic [31:0]       txcnt,
    output logic              tx_valid,
    input  logic              tx_ready,
    output logic [DATA_W-1:0] tx_data,
    output logic              tx_sop,
    output logic              tx_eop,
    output logic [1:0]        tx_empty
);
    seq_st_e           st;
    logic [31:0]       remaining;
    logic              stop_pend;
    logic [LEN_W-1:0]  plen;
    logic [BEAT_W-1:0] nbeats;
    logic [BEAT_W-1:0] beat;
    logic [1:0]        last_empty;

    logic              fire, last, cont, launch_idle, launch_next;
    logic [LEN_W-1:0]  new_len;
    logic [LEN_W:0]    new_total;
    logic [BYTE_W-1:0] total_q;

    assign fire        = (st == ST_SEND) && tx_ready;
    assign last        = (beat == nbeats - 1'b1);
    assign cont        = (remaining != 32'd1) && !stop_pend && !stop_p;
    assign launch_idle = (st == ST_IDLE) && start_p && (cfg.nframes != 32'd0);
    assign launch_next = fire && last && cont;
    assign lfsr_step   = launch_idle || fire;
    assign new_len     = draw_len(rnd, cfg.rand_len, cfg.plen);
    assign new_total   = (LEN_W+1)'(new_len) + (LEN_W+1)'(HDR_BYTES);
    assign total_q     = BYTE_W'(plen) + BYTE_W'(HDR_BYTES);

    always_ff @(posedge clk) begin
        if (rst) begin
            st         <= ST_IDLE;
            remaining  <= '0;
            stop_pend  <= 1'b0;
            plen       <= '0;
            nbeats     <= '0;
            beat       <= '0;
            last_empty <= '0;
            txcnt      <= '0;
        end else begin
            if (st == ST_IDLE)  stop_pend <= 1'b0;
            else if (stop_p)    stop_pend <= 1'b1;
            if (st == ST_IDLE && start_p) txcnt <= '0;
            if (launch_idle) begin
                st        <= ST_SEND;
                remaining <= cfg.nframes;
            end
            if (fire && last) begin
                txcnt     <= txcnt + 1'b1;
                remaining <= remaining - 1'b1;
                if (!cont) st <= ST_IDLE;
            end
            if (launch_idle || launch_next) begin
                plen       <= new_len;
                nbeats     <= BEAT_W'((new_total + 3'd3) >> 2);
                beat       <= '0;
                last_empty <= 2'(3'd4 - {1'b0, new_total[1:0]});
            end else if (fire) begin
                beat <= beat + 1'b1;
            end
        end
    end

    assign tx_valid = (st == ST_SEND);
    assign tx_sop   = tx_valid && (beat == '0);
    assign tx_eop   = tx_valid && last;
    assign tx_empty = tx_eop ? last_empty : 2'd0;

    for (genvar j = 0; j < LANES; j++) begin : g_lane
        logic [BYTE_W-1:0] idx;
        logic [7:0]        b;
        always_comb begin
            idx = BYTE_W'(beat) * BYTE_W'(LANES) + BYTE_W'(j);
            if (idx < BYTE_W'(HDR_BYTES))
                b = hdr_byte(idx[3:0], cfg.da, cfg.sa, plen);
            else if (idx < total_q)
                b = cfg.rand_pay ? rnd[DATA_W-1-8*j -: 8] : 8'(idx - BYTE_W'(HDR_BYTES));
            else
                b = 8'd0;
        end
        assign tx_data[DATA_W-1-8*j -: 8] = b;
    end

    assert_stall_hold_R12: assert property (@(posedge clk) disable iff (rst)
        (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data) && $stable(tx_sop)
                                     && $stable(tx_eop) && $stable(tx_empty)));
    assert_empty_eop_R11: assert property (@(posedge clk) disable iff (rst)
        (tx_valid && !tx_eop) |-> tx_empty == 2'd0);
    assert_txcnt_step_R3: assert property (@(posedge clk) disable iff (rst)
        !start_p |=> (txcnt == $past(txcnt) || txcnt == $past(txcnt) + 32'd1));
    assert_txcnt_clear_R3: assert property (@(posedge clk) disable iff (rst)
        (st == ST_IDLE && start_p) |=> txcnt == 32'd0);
    assert_run_end_R4: assert property (@(posedge clk) disable iff (rst)
        (tx_eop && tx_ready && remaining == 32'd1) |=> !tx_valid);
endmodule

// File: rtl/eth_frame_gen.sv
module eth_frame_gen
    import efg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              tx_valid,
    input  logic              tx_ready,
    output logic [DATA_W-1:0] tx_data,
    output logic              tx_sop,
    output logic              tx_eop,
    output logic [1:0]        tx_empty
);
    cfg_t        cfg;
    logic        start_p, stop_p, lfsr_step;
    logic [31:0] txcnt, rnd;

    efg_regs u_regs (
        .clk(clk), .rst(rst), .addr(reg_addr), .wr(reg_wr), .wdata(reg_wdata),
        .txcnt(txcnt), .rdata(reg_rdata), .cfg(cfg), .start_p(start_p), .stop_p(stop_p)
    );

    efg_lfsr u_lfsr (
        .clk(clk), .rst(rst), .step(lfsr_step), .state(rnd)
    );

    efg_seq u_seq (
        .clk(clk), .rst(rst), .cfg(cfg), .start_p(start_p), .stop_p(stop_p), .rnd(rnd),
        .lfsr_step(lfsr_step), .txcnt(txcnt), .tx_valid(tx_valid), .tx_ready(tx_ready),
        .tx_data(tx_data), .tx_sop(tx_sop), .tx_eop(tx_eop), .tx_empty(tx_empty)
    );
endmodule

// File: tb/test_eth_frame_gen.sv
`timescale 1ns/1ps
module test_eth_frame_gen;
    localparam logic [5:0] A_CNT = 6'h00, A_LM = 6'h04, A_PM = 6'h08, A_GO = 6'h0C,
                           A_HALT = 6'h10, A_SAL = 6'h14, A_SAH = 6'h18, A_DAL = 6'h1C,
                           A_DAH = 6'h20, A_TXC = 6'h24, A_LEN = 6'h34;
    localparam logic [31:0] SEED = 32'hACE12468;

    logic        clk = 1'b0, rst = 1'b1;
    logic [5:0]  reg_addr = '0;
    logic        reg_wr = 1'b0;
    logic [31:0] reg_wdata = '0, reg_rdata;
    logic        tx_valid, tx_ready = 1'b0, tx_sop, tx_eop;
    logic [31:0] tx_data;
    logic [1:0]  tx_empty;

    eth_frame_gen i_eth_frame_gen (
        .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
        .tx_sop(tx_sop), .tx_eop(tx_eop), .tx_empty(tx_empty)
    );

    always #2.5 clk = ~clk;

    int n_cmp = 0, n_bad = 0;
    int rmode = 0;

    // reference model state
    logic [31:0] m_lfsr = SEED;
    logic [47:0] m_da, m_sa;
    bit m_running = 0, m_fresh = 0, m_stop = 0, m_have = 0, m_rlen = 0, m_rpay = 0;
    int m_remaining = 0, m_len = 0, m_beat = 0, m_lim = 0, m_cnt = 0, frames_seen = 0;
    bit stall_prev = 0;
    logic [35:0] saved;

    task automatic chk(input string tag, input bit ok, input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] f_next(input logic [31:0] s);
        return {s[30:0], s[31] ^ s[21] ^ s[1] ^ s[0]};
    endfunction

    function automatic int f_len(input logic [31:0] r, input bit rnd, input int lim);
        longint v;
        if (rnd) v = (longint'(r[15:0]) * longint'(lim + 1)) >> 16;
        else     v = lim;
        if (v == 0) v = 1;
        return int'(v);
    endfunction

    function automatic logic [7:0] f_byte(input int idx, input int total, input int lane);
        if (idx < 6)   return m_da[8*(5-idx) +: 8];
        if (idx < 12)  return m_sa[8*(11-idx) +: 8];
        if (idx == 12) return 8'(m_len >> 8);
        if (idx == 13) return 8'(m_len);
        if (idx < total) return m_rpay ? m_lfsr[31-8*lane -: 8] : 8'(idx - 14);
        return 8'h00;
    endfunction

    always @(negedge clk) begin
        if (rmode == 0)      tx_ready = 1'b1;
        else if (rmode == 1) tx_ready = ($urandom % 4) != 0;
    end

    // stream monitor, samples just before the rising edge
    always begin
        @(negedge clk);
        #2;
        if (!rst) begin
            if (stall_prev)
                chk("R12 output held during stall", tx_valid && {tx_data, tx_sop, tx_eop, tx_empty} == saved,
                    64'({tx_data, tx_sop, tx_eop, tx_empty}), 64'(saved));
            stall_prev = tx_valid && !tx_ready;
            saved = {tx_data, tx_sop, tx_eop, tx_empty};
            if (tx_valid && tx_ready) begin : b_beat
                int total, nb;
                bit last;
                logic [31:0] exp_d;
                logic [1:0] ee;
                string s;
                if (!m_have) begin
                    if (m_fresh) begin
                        m_len = f_len(m_lfsr, m_rlen, m_lim);
                        m_lfsr = f_next(m_lfsr);
                        m_fresh = 0; m_have = 1; m_beat = 0;
                    end else begin
                        chk("R4 beat while no frame expected", 1'b0, 64'(tx_data), 64'd0);
                    end
                end
                if (m_have) begin
                    total = m_len + 14;
                    nb = (total + 3) / 4;
                    last = (m_beat == nb - 1);
                    for (int j = 0; j < 4; j++) exp_d[31-8*j -: 8] = f_byte(m_beat*4 + j, total, j);
                    ee = last ? 2'((4 - total % 4) % 4) : 2'd0;
                    if (m_rpay) s = "R6 R9 R10 R11 beat with random payload";
                    else        s = "R6 R10 R11 beat with incrementing payload";
                    chk(s, {tx_data, tx_sop, tx_eop, tx_empty} == {exp_d, m_beat == 0, last, ee},
                        64'({tx_data, tx_sop, tx_eop, tx_empty}), 64'({exp_d, m_beat == 0, last, ee}));
                    if (m_beat == 3) begin
                        if (m_rlen) s = "R8 random length field and bound";
                        else        s = "R7 fixed length field";
                        chk(s, tx_data[31:16] == 16'(m_len) && m_len <= ((m_lim == 0) ? 1 : m_lim),
                            64'(tx_data[31:16]), 64'(m_len));
                    end
                    if (last) begin
                        frames_seen++;
                        m_remaining--;
                        if (m_remaining > 0 && !m_stop) begin
                            m_len = f_len(m_lfsr, m_rlen, m_lim);
                            m_beat = 0;
                        end else begin
                            m_have = 0; m_running = 0;
                        end
                    end else begin
                        m_beat++;
                    end
                    m_lfsr = f_next(m_lfsr);
                end
            end
        end
    end

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [5:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic setup(input int cnt, input bit rl, input bit rp, input int lim);
        m_da = {16'($urandom), 32'($urandom)};
        m_sa = {16'($urandom), 32'($urandom)};
        m_cnt = cnt; m_rlen = rl; m_rpay = rp; m_lim = lim;
        wr(A_CNT, 32'(cnt)); wr(A_LM, 32'(rl)); wr(A_PM, 32'(rp)); wr(A_LEN, 32'(lim));
        wr(A_SAL, m_sa[31:0]); wr(A_SAH, {16'hFFFF, m_sa[47:32]});
        wr(A_DAL, m_da[31:0]); wr(A_DAH, {16'hFFFF, m_da[47:32]});
    endtask

    task automatic go();
        wr(A_GO, 32'd1);
        if (!m_running) begin
            m_remaining = m_cnt; m_running = (m_cnt != 0); m_fresh = (m_cnt != 0);
            m_have = 0; m_stop = 0;
        end
    endtask

    task automatic halt();
        wr(A_HALT, 32'd1);
        if (m_running) m_stop = 1;
    endtask

    task automatic finish_run(input string tag, input int f0, input int exp_frames);
        logic [31:0] v;
        for (int k = 0; k < 40000 && m_running; k++) @(negedge clk);
        repeat (12) @(negedge clk);
        chk({tag, " frame total"}, frames_seen - f0 == exp_frames, 64'(frames_seen - f0), 64'(exp_frames));
        chk("R4 valid low once run is over", !tx_valid, 64'(tx_valid), 64'd0);
        rd(A_TXC, v);
        chk("R3 transmitted count after run", v == 32'(exp_frames), 64'(v), 64'(exp_frames));
    endtask

    initial begin
        #1_000_000;
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] v;
        logic [5:0] offs [11] = '{A_CNT, A_LM, A_PM, A_GO, A_HALT, A_SAL, A_SAH, A_DAL, A_DAH, A_TXC, A_LEN};
        int f0;
        void'($urandom(32'd2016));
        repeat (5) @(negedge clk);
        rst = 1'b0;
        #1;
        chk("R1 valid low after reset", !tx_valid, 64'(tx_valid), 64'd0);
        foreach (offs[i]) begin
            rd(offs[i], v);
            chk("R1 register zero after reset", v == 32'd0, 64'(v), 64'd0);
        end

        // register readback
        wr(A_CNT, 32'hDEAD_0007); rd(A_CNT, v); chk("R1 frame count readback", v == 32'hDEAD_0007, 64'(v), 64'hDEAD0007);
        wr(A_LM, 32'h3); rd(A_LM, v); chk("R1 length mode bit 0", v == 32'd1, 64'(v), 64'd1);
        wr(A_LEN, 32'hABCD_1234); rd(A_LEN, v); chk("R1 payload length 16 bits", v == 32'h1234, 64'(v), 64'h1234);
        wr(A_SAH, 32'hFFFF_FFFF); rd(A_SAH, v); chk("R2 source high upper bits zero", v == 32'h0000_FFFF, 64'(v), 64'hFFFF);
        wr(A_DAH, 32'h5A5A_1234); rd(A_DAH, v); chk("R2 dest high upper bits zero", v == 32'h0000_1234, 64'(v), 64'h1234);
        wr(A_TXC, 32'h0000_0055); rd(A_TXC, v); chk("R3 write to count ignored", v == 32'd0, 64'(v), 64'd0);
        rd(6'h2C, v); chk("R1 unmapped offset reads zero", v == 32'd0, 64'(v), 64'd0);

        // fixed lengths including 0 and every residue of 4
        rmode = 0;
        foreach (offs[i]) begin
            int lens [7] = '{0, 1, 2, 3, 4, 5, 46};
            if (i < 7) begin
                f0 = frames_seen;
                setup(2, 0, i % 2, lens[i]);
                go();
                finish_run("R7 fixed length run", f0, 2);
            end
        end

        // count zero: nothing sent, count cleared by start
        f0 = frames_seen;
        setup(0, 0, 0, 8);
        go();
        finish_run("R4 zero frame count", f0, 0);

        // random lengths and payloads under random backpressure
        rmode = 1;
        for (int it = 0; it < 8; it++) begin
            int cnt;
            cnt = 2 + int'($urandom % 4);
            f0 = frames_seen;
            setup(cnt, (it % 4) != 0, it % 2, int'($urandom % 90));
            go();
            finish_run("R8 random run", f0, cnt);
        end

        // stop while idle has no effect
        halt();
        f0 = frames_seen;
        setup(2, 0, 0, 9);
        go();
        finish_run("R5 stop while idle ignored", f0, 2);

        // stop mid-frame: frame in flight completes, then idle
        rmode = 2; tx_ready = 1'b0;
        f0 = frames_seen;
        setup(10, 0, 1, 40);
        go();
        for (int k = 0; k < 50 && !tx_valid; k++) @(negedge clk);
        halt();
        rmode = 1;
        finish_run("R5 stop mid-frame", f0, 1);

        // stop pulse lands on the end-of-packet handshake
        rmode = 2; tx_ready = 1'b1;
        f0 = frames_seen;
        setup(5, 0, 0, 6);
        go();
        for (int k = 0; k < 200; k++) begin
            @(negedge clk);
            if (tx_valid && tx_eop) break;
        end
        tx_ready = 1'b0;
        reg_addr = A_HALT; reg_wdata = 32'd1; reg_wr = 1'b1;
        m_stop = 1;
        @(negedge clk);
        reg_wr = 1'b0; tx_ready = 1'b1;
        finish_run("R5 stop coinciding with last beat", f0, 1);

        // start during a run is ignored
        rmode = 0;
        f0 = frames_seen;
        setup(4, 0, 1, 10);
        go();
        for (int k = 0; k < 500 && frames_seen < f0 + 1; k++) @(negedge clk);
        wr(A_GO, 32'd1);
        finish_run("R4 start during run ignored", f0, 4);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule